// File: doc/BRIEF.md
# GPIO Edge Interrupt Generator with Trigger Lockout

This block turns level changes on a port of general-purpose input pins into a single shared interrupt request. Every pin carries its own enable bit and its own edge-direction bit. A pin qualifies only when its enable bit and the main GPIO interrupt enable are both set. When a qualifying edge arrives, a pending flag is raised. A one-cycle acknowledge pulse clears that flag. Firmware reads the port itself to find out which pin fired. The block assigns no priority among pins.

The pins enter asynchronously and pass through a two-flop synchronizer before edge detection. After a pin triggers, the block records that pin as the lockout holder. While the holder is recorded, no pin can raise a new request. The lockout ends when the holder's synchronized level returns to its idle value or when software clears the holder's enable bit. The acknowledge never changes the configuration registers.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, `irq` is 0 and both `cfg_en` and `cfg_pol` read all zeros.
- R2: With direction bit 0, a high-to-low change on an enabled pin raises `irq`.
- R3: With direction bit 1, a low-to-high change on an enabled pin raises `irq`, and a high-to-low change on that pin does not.
- R4: An edge raises a request only when the pin's enable bit is 1 and `main_en` is 1. `irq` is also held at 0 whenever `main_en` is 0.
- R5: All pins share the single `irq` output. An edge on any enabled pin sets it, and it stays set until acknowledged.
- R6: Once a pin has triggered, no pin can set a new request until that holder pin is back at its idle level. The idle level is high for direction 0 and low for direction 1.
- R7: Clearing the holder pin's enable bit also ends the lockout, so later edges on other pins can trigger again.
- R8: A one-cycle `ack` clears `irq` at the next clock edge and leaves `cfg_en` and `cfg_pol` unchanged. If a new qualifying edge is accepted in that same cycle, the new request wins.
- R9: A pin change presented before a clock edge shows up on `irq` right after the third rising edge, and not earlier.
- R10: A write with `reg_wr`=1 loads `reg_wdata` into the enable register when `reg_sel`=0 and into the direction register when `reg_sel`=1. The new value is readable on `cfg_en`/`cfg_pol` after the next edge. Without a write, both registers hold their values.
- R11: When several pins trigger in the same cycle, the lowest-index one becomes the lockout holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | NPINS | Raw pin levels, not yet synchronized |
| main_en | input | 1 | Main GPIO interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 = enable register, 1 = direction register |
| reg_wdata | input | NPINS | Write data |
| ack | input | 1 | One-cycle interrupt acknowledge |
| cfg_en | output | NPINS | Current per-pin enable register |
| cfg_pol | output | NPINS | Current per-pin direction register (1 = rising) |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench drives falling edges under direction 0 and rising edges under direction 1. It also drives the opposite edge in each case, which shows whether the direction bit really selects the edge. Edges are driven on pins whose own enable or main enable is off, which separates the two gating terms. A second pin is toggled while the first pin stays active, once with the holder released by returning to idle and once by clearing its enable. This shows that the lockout follows the holder and not the request flag. Two pins falling in the same cycle, followed by a toggle of the higher-index pin, shows whether the lowest-index pin was chosen as holder.

// File: rtl/gpio_irq_pkg.sv
// Package: shared constants and types for the GPIO edge interrupt block.
// Assumes: nothing beyond IEEE 1800-2017.
package gpio_irq_pkg;

    // Write target selector on the register interface.
    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_POLARITY = 1'b1
    } cfg_sel_e;

    // Direction-bit meaning.
    localparam logic POL_FALL = 1'b0;
    localparam logic POL_RISE = 1'b1;

endpackage

// File: rtl/gpio_irq_sync.sv
// Module: multi-flop synchronizer for a bus of independent pin levels.
// Assumes: each bit is an independent slow level; no bus coherency needed.
module gpio_irq_sync #(
    parameter int NPINS = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] din,
    output logic [NPINS-1:0] dout
);
    logic [NPINS-1:0] stage_q [STAGES];

    // Shift the raw levels through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_cfg.sv
// Module: per-pin enable and edge-direction registers.
// Assumes: single write strobe; both registers clear on reset.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] en_q,
    output logic [NPINS-1:0] pol_q
);
    // Load the selected register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else if (wr) begin
            if (cfg_sel_e'(sel) == SEL_ENABLE) en_q  <= wdata;
            else                               pol_q <= wdata;
        end
    end
endmodule

// File: rtl/gpio_irq_edge.sv
// Module: per-pin edge detector with direction select and enable gating.
// Assumes: lvl is already synchronized to clk.
module gpio_irq_edge #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] en,
    input  logic [NPINS-1:0] pol,
    input  logic             main_en,
    output logic [NPINS-1:0] trig
);
    logic [NPINS-1:0] prev_q;

    // Remember last cycle's synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise_w;
        logic fall_w;
        // Form the selected edge for this pin.
        always_comb begin
            rise_w  = lvl[i] & ~prev_q[i];
            fall_w  = ~lvl[i] & prev_q[i];
            trig[i] = (pol[i] ? rise_w : fall_w) & en[i] & main_en;
        end
    end
endmodule

// File: rtl/gpio_irq_lock.sv
// Module: shared pending flag and single-holder trigger lockout.
// Assumes: trig already qualified by enables; lvl synchronized.
module gpio_irq_lock #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] trig,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] en,
    input  logic [NPINS-1:0] pol,
    input  logic             ack,
    output logic             pend_q,
    output logic             lock_valid,
    output logic             accept
);
    localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1;

    logic [IDXW-1:0] lock_idx_q;
    logic [IDXW-1:0] first_idx;
    logic            any_trig;
    logic            holder_active;
    logic            release_w;

    // Pick the lowest-index triggering pin.
    always_comb begin
        first_idx = '0;
        any_trig  = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            if (trig[i] && !any_trig) begin
                first_idx = IDXW'(i);
                any_trig  = 1'b1;
            end
        end
    end

    // Decide whether the recorded holder frees the lockout.
    always_comb begin
        holder_active = pol[lock_idx_q] ? lvl[lock_idx_q] : ~lvl[lock_idx_q];
        release_w     = ~holder_active | ~en[lock_idx_q];
        accept        = any_trig & ~lock_valid;
    end

    // Track the lockout holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_valid <= 1'b0;
            lock_idx_q <= '0;
        end else if (accept) begin
            lock_valid <= 1'b1;
            lock_idx_q <= first_idx;
        end else if (lock_valid && release_w) begin
            lock_valid <= 1'b0;
        end
    end

    // Pending request: set by accepted edge, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (accept) pend_q <= 1'b1;
        else if (ack)    pend_q <= 1'b0;
    end
endmodule

// File: rtl/gpio_irq_port.sv
// Module: top of the GPIO edge interrupt generator.
// Assumes: pin_async may be asynchronous; all other inputs are on clk.
module gpio_irq_port #(
    parameter int NPINS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_async,
    input  logic             main_en,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [NPINS-1:0] reg_wdata,
    input  logic             ack,
    output logic [NPINS-1:0] cfg_en,
    output logic [NPINS-1:0] cfg_pol,
    output logic             irq
);
    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] trig;
    logic             pend_q;
    logic             lock_valid;
    logic             accept;

    gpio_irq_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_async), .dout(lvl)
    );

    gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .en_q(cfg_en), .pol_q(cfg_pol)
    );

    gpio_irq_edge #(.NPINS(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .en(cfg_en), .pol(cfg_pol),
        .main_en(main_en), .trig(trig)
    );

    gpio_irq_lock #(.NPINS(NPINS)) u_lock (
        .clk(clk), .rst_n(rst_n), .trig(trig), .lvl(lvl), .en(cfg_en),
        .pol(cfg_pol), .ack(ack), .pend_q(pend_q), .lock_valid(lock_valid),
        .accept(accept)
    );

    // Present the request only while the main enable is on.
    assign irq = pend_q & main_en;
endmodule

// File: rtl/gpio_irq_port_chk.sv
// Module: assertion checker bound to gpio_irq_port.
// Assumes: observes top ports and the lock stage outputs only.
module gpio_irq_port_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             main_en,
    input logic             reg_wr,
    input logic [NPINS-1:0] cfg_en,
    input logic [NPINS-1:0] cfg_pol,
    input logic             irq,
    input logic             pend,
    input logic             lock_valid,
    input logic             accept
);
    AST_ACCEPT_NEEDS_MAIN: assert property (@(posedge clk) disable iff (!rst_n) accept |-> main_en); // R4
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !main_en |-> !irq); // R4
    AST_ACCEPT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n) accept |=> pend); // R5
    AST_ACCEPT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n) accept |=> lock_valid); // R6
    AST_PEND_ONLY_BY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) $rose(pend) |-> $past(accept)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ack && !accept) |=> !pend); // R8
    AST_CFG_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !reg_wr |=> $stable(cfg_en)); // R10
    AST_CFG_POL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !reg_wr |=> $stable(cfg_pol)); // R10
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .main_en(main_en), .reg_wr(reg_wr),
    .cfg_en(cfg_en), .cfg_pol(cfg_pol), .irq(irq), .pend(pend_q),
    .lock_valid(lock_valid), .accept(accept)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_async = '1;
    logic         main_en = 1'b0;
    logic         reg_wr = 1'b0;
    logic         reg_sel = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic         ack = 1'b0;
    logic [N-1:0] cfg_en;
    logic [N-1:0] cfg_pol;
    logic         irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    gpio_irq_port #(.NPINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .main_en(main_en),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ack(ack),
        .cfg_en(cfg_en), .cfg_pol(cfg_pol), .irq(irq)
    );

    // Reference model: pin history queue (newest first) plus behavioural state.
    logic [N-1:0] hist [$];
    bit           m_pend = 0;
    bit           m_lock = 0;
    int           m_holder = 0;
    logic [N-1:0] m_en = '0;
    logic [N-1:0] m_pol = '0;

    initial hist = '{'0, '0, '0};

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{'0, '0, '0};
            m_pend = 0; m_lock = 0; m_holder = 0; m_en = '0; m_pol = '0;
        end else begin
            logic [N-1:0] cur;
            logic [N-1:0] old;
            int first;
            bit act;
            cur = hist[1];
            old = hist[2];
            first = -1;
            for (int i = 0; i < N; i++) begin
                bit edge_ok;
                edge_ok = m_pol[i] ? (cur[i] && !old[i]) : (!cur[i] && old[i]);
                if (edge_ok && m_en[i] && main_en && first < 0) first = i;
            end
            act = (first >= 0) && !m_lock;
            if (act) m_pend = 1;
            else if (ack) m_pend = 0;
            if (act) begin
                m_lock = 1; m_holder = first;
            end else if (m_lock) begin
                bit active;
                active = m_pol[m_holder] ? cur[m_holder] : !cur[m_holder];
                if (!active || !m_en[m_holder]) m_lock = 0;
            end
            if (reg_wr) begin
                if (reg_sel) m_pol = reg_wdata;
                else         m_en = reg_wdata;
            end
            hist.push_front(pin_async);
            void'(hist.pop_back());
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk({cur_req, " irq"}, 32'(irq), 32'(m_pend && main_en));
            chk({cur_req, " cfg_en"}, 32'(cfg_en), 32'(m_en));
            chk({cur_req, " cfg_pol"}, 32'(cfg_pol), 32'(m_pol));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(bit sel, logic [N-1:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        cur_req = "R1";
        chk("R1 irq", 32'(irq), 0);
        chk("R1 cfg_en", 32'(cfg_en), 0);
        chk("R1 cfg_pol", 32'(cfg_pol), 0);
        cyc(4);

        // R10: register writes and readback
        cur_req = "R10";
        wr_reg(1'b0, 8'h0F);
        chk("R10 enable write", 32'(cfg_en), 32'h0F);
        wr_reg(1'b1, 8'h00);
        chk("R10 polarity write", 32'(cfg_pol), 32'h00);

        // R4: main enable off, then pin enable off
        cur_req = "R4";
        pin_async[0] = 1'b0; cyc(5);
        chk("R4 main_en off", 32'(irq), 0);
        pin_async[0] = 1'b1; cyc(5);
        main_en = 1'b1; cyc(2);
        pin_async[4] = 1'b0; cyc(5);
        chk("R4 pin disabled", 32'(irq), 0);
        pin_async[4] = 1'b1; cyc(5);

        // R2 / R9: falling edge, latency of three edges
        cur_req = "R2";
        pin_async[0] = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R9 not before third edge", 32'(irq), 0);
        @(posedge clk); #1;
        chk("R2 falling edge raises irq", 32'(irq), 1);
        @(negedge clk);

        // R8: acknowledge clears, enables untouched
        cur_req = "R8";
        ack = 1'b1;
        @(posedge clk); #1;
        chk("R8 ack clears irq", 32'(irq), 0);
        chk("R8 ack keeps enables", 32'(cfg_en), 32'h0F);
        @(negedge clk); ack = 1'b0;

        // R6: lockout held by pin0 while it stays low
        cur_req = "R6";
        pin_async[1] = 1'b0; cyc(5);
        chk("R6 locked by pin0", 32'(irq), 0);
        pin_async[0] = 1'b1; cyc(5);
        chk("R6 no stale edge after release", 32'(irq), 0);
        cur_req = "R5";
        pin_async[1] = 1'b1; cyc(3);
        pin_async[1] = 1'b0; cyc(4);
        chk("R5 other pin shares irq", 32'(irq), 1);
        pulse_ack(); cyc(2);
        chk("R5 stays clear after ack", 32'(irq), 0);

        // R7: clearing holder enable releases the lockout
        cur_req = "R7";
        pin_async[2] = 1'b0; cyc(5);
        chk("R7 locked by pin1", 32'(irq), 0);
        wr_reg(1'b0, 8'h0D); cyc(2);
        pin_async[2] = 1'b1; cyc(3);
        pin_async[2] = 1'b0; cyc(4);
        chk("R7 release by enable clear", 32'(irq), 1);
        pulse_ack();
        pin_async = '1; cyc(4);
        wr_reg(1'b0, 8'h0F); cyc(3);

        // R3: rising edges with direction bit 1
        cur_req = "R3";
        wr_reg(1'b1, 8'h0F); cyc(3);
        pin_async[3] = 1'b0; cyc(5);
        chk("R3 falling ignored when rising selected", 32'(irq), 0);
        pin_async[3] = 1'b1; cyc(4);
        chk("R3 rising edge raises irq", 32'(irq), 1);
        pulse_ack();
        pin_async[3] = 1'b0; cyc(4);
        wr_reg(1'b1, 8'h00); cyc(2);
        pin_async[3] = 1'b1; cyc(4);
        pulse_ack(); cyc(3);

        // R11: simultaneous trigger, lowest index holds
        cur_req = "R11";
        pin_async[1] = 1'b0; pin_async[2] = 1'b0; cyc(4);
        chk("R11 simultaneous raises irq", 32'(irq), 1);
        pulse_ack();
        pin_async[2] = 1'b1; cyc(3);
        pin_async[2] = 1'b0; cyc(5);
        chk("R11 pin1 still holds lockout", 32'(irq), 0);
        pin_async[1] = 1'b1; cyc(3);
        pin_async[3] = 1'b0; cyc(4);
        chk("R11 release then new trigger", 32'(irq), 1);

        // R4: irq masked by main enable while pending
        cur_req = "R4";
        main_en = 1'b0; cyc(1);
        chk("R4 irq masked", 32'(irq), 0);
        main_en = 1'b1; cyc(1);
        chk("R4 pending shown again", 32'(irq), 1);
        pulse_ack(); cyc(3);

        finish_run();
    end
endmodule